// File: doc/BRIEF.md
# Qui-binary decimal digit adder

This block adds one pair of decimal digits together with a carry from the next lower digit position. The operands arrive as 4-bit BCD values and the result leaves as a 4-bit BCD value with a decimal carry out. Internally each digit is recoded into a hidden qui-binary form. That form has a two-wire parity section, with one wire for even and one for odd, and a five-wire one-hot section whose wires weigh 0, 2, 4, 6 and 8. The parity sections and the weighted sections are summed by two separate sub-adders, with a carry passing from the parity adder into the weighted adder. The result is then recoded to BCD.

Operand B can be turned into its nines-complement (9 - B) before it reaches the adders, so a digit-serial controller can use the same block for subtraction. The complement is formed in the qui-binary domain: the parity wires are swapped and the five weighted wires are mirrored. Every qui-binary code (both operands and the sum) is checked for exactly one active wire per section, and any violation raises a code error. A BCD value of 10 to 15 cannot be encoded, so it always raises the error.

Results are captured on a clock edge at which the input strobe is high. A two-state flow controller presents the valid flag in the cycle that follows. Its states are ST_IDLE, in which no fresh result is shown, and ST_SHOW, in which the registered result is fresh. The transitions are: ST_IDLE to ST_SHOW when the strobe is high, ST_SHOW to ST_SHOW when the strobe is high again, and ST_SHOW to ST_IDLE when the strobe is low.

Top module: `quibin_digit_adder`

## Requirements
- R1: For BCD operands (0 to 9), the cycle after a strobe shows sum_digit = (digit_a + B' + carry_in) mod 10 and carry_out = 1 exactly when that total is 10 or more. B' is digit_b when comp_b = 0.
- R2: With comp_b = 1, B' = 9 - digit_b. For example, digit_a = 3, digit_b = 0, comp_b = 1 and carry_in = 1 give sum_digit 3 and carry_out 1.
- R3: carry_in = 1 adds exactly one to the total. The highest case is 9 + 9 + 1, which gives sum_digit 9 and carry_out 1.
- R4: If digit_a or digit_b is 10 to 15 at a strobe, then in the next cycle code_err = 1, sum_digit = 0 and carry_out = 0.
- R5: If both operands are 0 to 9 at a strobe, code_err = 0 in the next cycle.
- R6: sum_digit, carry_out and code_err change only at an edge where in_valid = 1. Operand values present while in_valid = 0 have no effect on them.
- R7: out_valid is 1 in the cycle after an edge with in_valid = 1 (state ST_SHOW) and is 0 after an edge with in_valid = 0 (state ST_IDLE).
- R8: While rst_n = 0, sum_digit, carry_out, code_err and out_valid are all 0 and the controller is in ST_IDLE.
- R9: Whenever out_valid = 1, sum_digit is a BCD value (9 or less).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: capture the result of the present operands |
| digit_a | input | 4 | BCD operand A |
| digit_b | input | 4 | BCD operand B |
| comp_b | input | 1 | 1 = use nines-complement of operand B |
| carry_in | input | 1 | Decimal carry from the lower digit position |
| sum_digit | output | 4 | Registered BCD sum digit |
| carry_out | output | 1 | Registered decimal carry to the next digit position |
| code_err | output | 1 | Registered qui-binary validity error |
| out_valid | output | 1 | High in the cycle after a strobe |

## Verification
The only state is the output register and the two-state flow controller. A fault therefore reaches the ports in the first cycle after the strobe that exposes it. If a wire in the encoder mirror or in the weighted sub-adder is misrouted, a specific set of operand pairs returns a wrong digit or carry. For this reason the full 10 x 10 operand space is swept with both complement settings and both carry values. A flow controller stuck in one state shows as an out_valid that fails to track the strobe, and leakage through the capture enable shows as outputs that move during idle cycles while the operand inputs are toggled.

// File: rtl/quibin_pkg.sv
package quibin_pkg;
    localparam int BCD_W = 4;
    localparam int BIN_N = 2;
    localparam int QUI_N = 5;
    localparam int IDX_W = $clog2(QUI_N);
    localparam int TOT_W = IDX_W + 1;
    localparam int MAX_DIGIT = 2 * QUI_N - 1;

    // bin[0] = even wire, bin[1] = odd wire; qui[i] has weight 2*i
    typedef struct packed {
        logic [BIN_N-1:0] bin;
        logic [QUI_N-1:0] qui;
    } qb_code_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } flow_state_t;
endpackage

// File: rtl/qb_encoder.sv
module qb_encoder
    import quibin_pkg::*;
(
    input  logic [BCD_W-1:0] bcd,
    input  logic             mirror,
    output qb_code_t         code
);
    logic             in_range;
    logic [IDX_W-1:0] half;
    logic [QUI_N-1:0] raw_qui;
    logic [BIN_N-1:0] raw_bin;

    assign in_range = (bcd <= BCD_W'(MAX_DIGIT));
    assign half     = bcd[BCD_W-1:1];
    assign raw_bin  = in_range ? {bcd[0], ~bcd[0]} : '0;

    genvar i;
    generate
        for (i = 0; i < QUI_N; i++) begin : g_qui
            assign raw_qui[i] = in_range && (half == IDX_W'(i));
            // nines-complement mirrors the weighted section
            assign code.qui[i] = mirror ? raw_qui[QUI_N-1-i] : raw_qui[i];
        end
    endgenerate

    // nines-complement also flips parity
    assign code.bin = mirror ? {raw_bin[0], raw_bin[1]} : raw_bin;
endmodule

// File: rtl/qb_bin_adder.sv
module qb_bin_adder
    import quibin_pkg::*;
(
    input  logic [BIN_N-1:0] bin_a,
    input  logic [BIN_N-1:0] bin_b,
    input  logic             carry_in,
    output logic [BIN_N-1:0] bin_sum,
    output logic             carry_up
);
    logic [1:0] odd_total;

    always_comb begin
        odd_total = {1'b0, bin_a[1]} + {1'b0, bin_b[1]} + {1'b0, carry_in};
        bin_sum   = {odd_total[0], ~odd_total[0]};
        carry_up  = odd_total[1];
    end
endmodule

// File: rtl/qb_qui_adder.sv
module qb_qui_adder
    import quibin_pkg::*;
(
    input  logic [QUI_N-1:0] qui_a,
    input  logic [QUI_N-1:0] qui_b,
    input  logic             carry_lo,
    output logic [QUI_N-1:0] qui_sum,
    output logic             carry_out
);
    logic [IDX_W-1:0] idx_a;
    logic [IDX_W-1:0] idx_b;
    logic [TOT_W-1:0] total;
    logic [TOT_W-1:0] wrapped;

    always_comb begin
        idx_a = '0;
        idx_b = '0;
        for (int k = 0; k < QUI_N; k++) begin
            if (qui_a[k]) idx_a = idx_a | IDX_W'(k);
            if (qui_b[k]) idx_b = idx_b | IDX_W'(k);
        end
        total = {1'b0, idx_a} + {1'b0, idx_b} + TOT_W'(carry_lo);
        if (total >= TOT_W'(QUI_N)) begin
            wrapped   = total - TOT_W'(QUI_N);
            carry_out = 1'b1;
        end else begin
            wrapped   = total;
            carry_out = 1'b0;
        end
    end

    genvar i;
    generate
        for (i = 0; i < QUI_N; i++) begin : g_onehot
            assign qui_sum[i] = (wrapped == TOT_W'(i));
        end
    endgenerate
endmodule

// File: rtl/qb_decoder.sv
module qb_decoder
    import quibin_pkg::*;
(
    input  qb_code_t         code_a,
    input  qb_code_t         code_b,
    input  qb_code_t         code_s,
    input  logic             carry_raw,
    output logic [BCD_W-1:0] digit,
    output logic             carry,
    output logic             bad
);
    logic [IDX_W-1:0] idx_s;
    logic             bad_a;
    logic             bad_b;
    logic             bad_s;

    always_comb begin
        bad_a = ($countones(code_a.bin) != 1) || ($countones(code_a.qui) != 1);
        bad_b = ($countones(code_b.bin) != 1) || ($countones(code_b.qui) != 1);
        bad_s = ($countones(code_s.bin) != 1) || ($countones(code_s.qui) != 1);
        bad   = bad_a || bad_b || bad_s;
        idx_s = '0;
        for (int k = 0; k < QUI_N; k++) begin
            if (code_s.qui[k]) idx_s = idx_s | IDX_W'(k);
        end
        digit = bad ? '0 : {idx_s, code_s.bin[1]};
        carry = bad ? 1'b0 : carry_raw;
    end
endmodule

// File: rtl/quibin_digit_adder.sv
module quibin_digit_adder
    import quibin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [BCD_W-1:0] digit_a,
    input  logic [BCD_W-1:0] digit_b,
    input  logic             comp_b,
    input  logic             carry_in,
    output logic [BCD_W-1:0] sum_digit,
    output logic             carry_out,
    output logic             code_err,
    output logic             out_valid
);
    qb_code_t         code_a;
    qb_code_t         code_b;
    qb_code_t         code_s;
    logic             carry_mid;
    logic             carry_hi;
    logic [BCD_W-1:0] dec_digit;
    logic             dec_carry;
    logic             dec_bad;
    flow_state_t      state_q;
    flow_state_t      state_d;

    qb_encoder enc_a_i (
        .bcd    (digit_a),
        .mirror (1'b0),
        .code   (code_a)
    );

    qb_encoder enc_b_i (
        .bcd    (digit_b),
        .mirror (comp_b),
        .code   (code_b)
    );

    qb_bin_adder bin_add_i (
        .bin_a    (code_a.bin),
        .bin_b    (code_b.bin),
        .carry_in (carry_in),
        .bin_sum  (code_s.bin),
        .carry_up (carry_mid)
    );

    qb_qui_adder qui_add_i (
        .qui_a     (code_a.qui),
        .qui_b     (code_b.qui),
        .carry_lo  (carry_mid),
        .qui_sum   (code_s.qui),
        .carry_out (carry_hi)
    );

    qb_decoder dec_i (
        .code_a    (code_a),
        .code_b    (code_b),
        .code_s    (code_s),
        .carry_raw (carry_hi),
        .digit     (dec_digit),
        .carry     (dec_carry),
        .bad       (dec_bad)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_SHOW;
            ST_SHOW: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_digit <= '0;
            carry_out <= 1'b0;
            code_err  <= 1'b0;
        end else if (in_valid) begin
            sum_digit <= dec_digit;
            carry_out <= dec_carry;
            code_err  <= dec_bad;
        end
    end

    assign out_valid = (state_q == ST_SHOW);
endmodule

// File: rtl/quibin_digit_adder_chk.sv
module quibin_digit_adder_chk
    import quibin_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [BCD_W-1:0] digit_a,
    input logic [BCD_W-1:0] digit_b,
    input logic             comp_b,
    input logic             carry_in,
    input logic [BCD_W-1:0] sum_digit,
    input logic             carry_out,
    input logic             code_err,
    input logic             out_valid
);
    logic       ops_ok;
    logic [4:0] ref_total;
    logic [4:0] got_total;

    always_comb begin
        ops_ok    = (digit_a <= 4'd9) && (digit_b <= 4'd9);
        ref_total = {1'b0, digit_a}
                  + (comp_b ? (5'd9 - {1'b0, digit_b}) : {1'b0, digit_b})
                  + {4'b0, carry_in};
        got_total = {1'b0, sum_digit} + (carry_out ? 5'd10 : 5'd0);
    end

    // R1
    sum_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ops_ok) |=> (got_total == $past(ref_total)));

    // R4
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ops_ok) |=> (code_err && sum_digit == 4'd0 && !carry_out));

    // R5
    good_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ops_ok) |=> !code_err);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_digit) && $stable(carry_out) && $stable(code_err)));

    // R7
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (sum_digit <= 4'd9));
endmodule

bind quibin_digit_adder quibin_digit_adder_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .digit_a   (digit_a),
    .digit_b   (digit_b),
    .comp_b    (comp_b),
    .carry_in  (carry_in),
    .sum_digit (sum_digit),
    .carry_out (carry_out),
    .code_err  (code_err),
    .out_valid (out_valid)
);

// File: tb/quibin_digit_adder_tb_top.sv
module quibin_digit_adder_tb_top;
    logic       clk;
    logic       rst_n;
    logic       in_valid;
    logic [3:0] digit_a;
    logic [3:0] digit_b;
    logic       comp_b;
    logic       carry_in;
    logic [3:0] sum_digit;
    logic       carry_out;
    logic       code_err;
    logic       out_valid;

    int checks_run  = 0;
    int checks_fail = 0;

    typedef struct {
        logic [3:0] s;
        logic       c;
        logic       e;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t last_exp;

    quibin_digit_adder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .digit_a   (digit_a),
        .digit_b   (digit_b),
        .comp_b    (comp_b),
        .carry_in  (carry_in),
        .sum_digit (sum_digit),
        .carry_out (carry_out),
        .code_err  (code_err),
        .out_valid (out_valid)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks_run++;
        if (!ok) begin
            checks_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // driver: applies one strobe and pushes the expected result
    task automatic send(input int a, input int b, input bit cmp, input bit cin,
                        input string tag);
        exp_t e;
        int   bb;
        int   tot;
        @(negedge clk);
        digit_a  = 4'(a);
        digit_b  = 4'(b);
        comp_b   = cmp;
        carry_in = cin;
        in_valid = 1'b1;
        e.tag = tag;
        if (a > 9 || b > 9) begin
            e.s = 4'd0; e.c = 1'b0; e.e = 1'b1;
        end else begin
            bb  = cmp ? 9 - b : b;
            tot = a + bb + int'(cin);
            e.s = 4'(tot % 10); e.c = (tot >= 10); e.e = 1'b0;
        end
        exp_q.push_back(e);
        last_exp = e;
    endtask

    // idle cycles with scrambled operands that must be ignored
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            digit_a  = 4'(k * 7 + 3);
            digit_b  = 4'(k * 5 + 11);
            comp_b   = k[0];
            carry_in = ~k[0];
        end
    endtask

    // monitor: pops the scoreboard when a result is presented
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "out_valid without strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(sum_digit == e.s, e.tag, "sum_digit", int'(sum_digit), int'(e.s));
                    check(carry_out == e.c, e.tag, "carry_out", int'(carry_out), int'(e.c));
                    check(code_err == e.e, e.tag, "code_err", int'(code_err), int'(e.e));
                    check(sum_digit <= 4'd9, "R9", "sum_digit range", int'(sum_digit), 9);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks_run++;
        checks_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks_run, checks_fail);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        digit_a  = 4'd0;
        digit_b  = 4'd0;
        comp_b   = 1'b0;
        carry_in = 1'b0;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(sum_digit == 4'd0, "R8", "sum_digit in reset", int'(sum_digit), 0);
        check(carry_out == 1'b0, "R8", "carry_out in reset", int'(carry_out), 0);
        check(code_err == 1'b0, "R8", "code_err in reset", int'(code_err), 0);
        check(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;

        // R3 corner: maximum total
        send(9, 9, 1'b0, 1'b1, "R3");
        // R2 corner: complement of 0 plus carry
        send(3, 0, 1'b1, 1'b1, "R2");
        send(0, 0, 1'b0, 1'b0, "R1");
        send(0, 9, 1'b1, 1'b0, "R2");
        idle(3);
        // R6 hold and R7 drop after idle cycles
        check(out_valid == 1'b0, "R7", "out_valid after idle", int'(out_valid), 0);
        check(sum_digit == last_exp.s, "R6", "sum_digit held", int'(sum_digit), int'(last_exp.s));
        check(carry_out == last_exp.c, "R6", "carry_out held", int'(carry_out), int'(last_exp.c));

        // R4 non-BCD operands
        send(10, 2, 1'b0, 1'b0, "R4");
        send(4, 15, 1'b1, 1'b1, "R4");
        send(12, 13, 1'b0, 1'b1, "R4");
        idle(2);
        check(code_err == 1'b1, "R6", "code_err held", int'(code_err), 1);
        // R5 error clears on a good pair
        send(5, 5, 1'b0, 1'b0, "R5");

        // full sweep: R1 plain, R2 complement, R3 with carry
        for (int a = 0; a < 10; a++) begin
            for (int b = 0; b < 10; b++) begin
                for (int m = 0; m < 4; m++) begin
                    send(a, b, m[1], m[0], m[1] ? "R2" : (m[0] ? "R3" : "R1"));
                end
            end
            idle(1);
        end
        idle(3);
        check(exp_q.size() == 0, "R7", "results pending", exp_q.size(), 0);
        check(out_valid == 1'b0, "R7", "out_valid at end", int'(out_valid), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks_run, checks_fail);
        $finish;
    end
endmodule